// File: doc/BRIEF.md
# Shared Front-End Core-to-Core Link

This block is the point-to-point link between the leading core of a shared front-end cluster and one follower core. It forms an extra pipeline stage that sits after issue and before operand read. Toward the follower it carries decoded instructions and cluster control messages (split or rejoin) on a 64-bit forward channel. Toward the leader it returns memory-completion acknowledgements on a 16-bit reverse channel. Both channel ends are inside the block. Packets are tagged, cut into channel beats, sent and put back together at the far end.

The whole block runs on the link clock, which is twice the core clock and synchronous to it. The input `phase` is high on the first link edge of every core cycle. The core-side valid/ready handshakes complete only on those edges, so the core pipeline sees one transfer opportunity per core cycle. Each channel end holds finished packets in a 2-entry buffer. While that buffer is full, no new packet starts on that channel.

Transmitter states: `SER_IDLE` (nothing held), `SER_HEAD` (first beat waiting for buffer room) and `SER_TAIL` (second beat on the wire). Transitions: load (IDLE or TAIL to HEAD), head-sent-two-beat (HEAD to TAIL), head-sent-one-beat (HEAD to IDLE, or back to HEAD on a fresh load), tail-sent (TAIL to IDLE). Receiver states: `DS_HEAD` (waiting for a first beat) and `DS_TAIL` (first beat held, waiting for the second). Transitions: two-beat head (HEAD to TAIL) and tail (TAIL to HEAD). A one-beat packet leaves the receiver in `DS_HEAD`.

Top module: `fe_link_top`

## Requirements
- R1: While reset is held and right after it is released, `pkt_valid`, `ack_out_valid`, `fwd_beat_vld` and `rev_beat_vld` are 0.
- R2: `ins_ready`, `ctl_ready` and `ack_in_ready` are 0 in every link cycle where `phase` is 0, so a core-side packet is only taken on a `phase`=1 edge. `phase` alternates 1,0,1,0 on successive link cycles.
- R3: An accepted instruction goes out as two forward beats on consecutive link cycles. The first beat appears in the link cycle after acceptance. First beat: bits [63:62] = 2'b00 and bits [61:0] = `ins_data[125:64]`. Second beat = `ins_data[63:0]`.
- R4: An accepted control message goes out as one forward beat {2'b10, `ctl_data[61:0]`}, in the link cycle after acceptance.
- R5: When `ctl_valid` and `ins_valid` are both 1 on an accepting edge, the control message is taken (`ctl_ready`=1) and `ins_ready` is 0.
- R6: With a follower that consumes every cycle, back-to-back instructions are accepted at every `phase`=1 edge, which is one per core cycle.
- R7: The follower output becomes valid in the link cycle after the last beat of a packet. `pkt_kind` is the tag. For an instruction, `pkt_data` = {first beat[61:0], second beat}. For a control message, it is `ctl_data` zero-extended.
- R8: An acknowledgement `ack_in_data[29:0]` goes out as two reverse beats: {2'b01, ack[29:16]}, then ack[15:0]. It is rebuilt on `ack_out_data` one link cycle after the second beat, and the rules of R2 and R7 apply to it as well.
- R9: While a receiver buffer holds 2 unconsumed packets, no beat goes out on that channel. At most one more packet is accepted into the transmitter while it is blocked.
- R10: Packets leave in the order they were accepted. An output packet stays valid and unchanged until it is consumed on a `phase`=1 edge with its ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock (twice core rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 1 | High on the first link edge of each core cycle |
| ins_valid | input | 1 | Leader offers a decoded instruction |
| ins_ready | output | 1 | Instruction taken this edge |
| ins_data | input | 126 | Instruction payload |
| ctl_valid | input | 1 | Leader offers a cluster control message |
| ctl_ready | output | 1 | Control message taken this edge |
| ctl_data | input | 62 | Control payload |
| pkt_valid | output | 1 | Follower-side packet available |
| pkt_ready | input | 1 | Follower pipeline consumes on phase edges |
| pkt_kind | output | 2 | Packet tag (00 instruction, 10 control) |
| pkt_data | output | 126 | Reassembled payload |
| ack_in_valid | input | 1 | Follower offers a memory acknowledgement |
| ack_in_ready | output | 1 | Acknowledgement taken this edge |
| ack_in_data | input | 30 | Acknowledgement payload |
| ack_out_valid | output | 1 | Leader-side acknowledgement available |
| ack_out_ready | input | 1 | Leader consumes on phase edges |
| ack_out_data | output | 30 | Rebuilt acknowledgement |
| fwd_beat_vld | output | 1 | Forward channel carries a beat |
| fwd_beat | output | 64 | Forward channel beat |
| rev_beat_vld | output | 1 | Reverse channel carries a beat |
| rev_beat | output | 16 | Reverse channel beat |

## Verification
The core-side ready signals are combinational: they are due in the same link cycle as the offer. The first beat of a packet is due one link cycle after its accepting edge, and the second beat one cycle after that. A rebuilt packet is due at the receiver output one link cycle after its last beat, and it can be consumed no earlier than the next `phase`=1 edge. The bench keeps a behavioural model made of queues of beats and finished packets. Inputs change on the falling edge. One nanosecond later the bench compares every port against the model's prediction for that same cycle and then advances the model across the coming rising edge, so each result is checked exactly in its due cycle.

// File: rtl/link_pkg.sv
package link_pkg;

    typedef enum logic [1:0] {
        KIND_INSTR = 2'b00,
        KIND_MACK  = 2'b01,
        KIND_CTRL  = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_e;

    localparam int TAG_W = 2;

endpackage

// File: rtl/link_ser.sv
module link_ser #(
    parameter  int BEAT_W = 64,
    localparam int PKT_W  = 2 * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              ld_en,
    input  logic [PKT_W-1:0]  ld_pkt,
    input  logic              ld_two,
    output logic              can_load,
    input  logic              ch_ready,
    output logic              beat_vld,
    output logic [BEAT_W-1:0] beat
);

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_HEAD,
        SER_TAIL
    } ser_state_e;

    ser_state_e         st_q, st_d;
    logic [PKT_W-1:0]   pkt_q;
    logic               two_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SER_IDLE;
            pkt_q <= '0;
            two_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ld_en) begin
                pkt_q <= ld_pkt;
                two_q <= ld_two;
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SER_IDLE: if (ld_en) st_d = SER_HEAD;
            SER_HEAD: begin
                if (ch_ready) begin
                    if (two_q)      st_d = SER_TAIL;
                    else if (ld_en) st_d = SER_HEAD;
                    else            st_d = SER_IDLE;
                end
            end
            SER_TAIL: st_d = ld_en ? SER_HEAD : SER_IDLE;
            default:  st_d = SER_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        beat_vld = 1'b0;
        can_load = 1'b0;
        unique case (st_q)
            SER_IDLE: begin
                beat_vld = 1'b0;
                can_load = phase;
            end
            SER_HEAD: begin
                beat_vld = ch_ready;
                can_load = phase && ch_ready && !two_q;
            end
            SER_TAIL: begin
                beat_vld = 1'b1;
                can_load = phase;
            end
            default: begin
                beat_vld = 1'b0;
                can_load = 1'b0;
            end
        endcase
        beat = (st_q == SER_TAIL) ? pkt_q[BEAT_W-1:0] : pkt_q[PKT_W-1:BEAT_W];
    end

    AST_TAIL_NEXT: assert property (@(posedge clk) disable iff (!rst_n) // R3
        (st_q == SER_HEAD && ch_ready && two_q) |=> (beat_vld && st_q == SER_TAIL));

endmodule

// File: rtl/link_deser.sv
module link_deser
    import link_pkg::*;
#(
    parameter  int         BEAT_W   = 64,
    parameter  logic [3:0] TWO_MASK = 4'b0001,
    parameter  int         DEPTH    = 2,
    localparam int         DATA_W   = 2 * BEAT_W - TAG_W,
    localparam int         PTR_W    = $clog2(DEPTH),
    localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              beat_vld,
    input  logic [BEAT_W-1:0] beat,
    output logic              ch_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TAG_W-1:0]  out_kind,
    output logic [DATA_W-1:0] out_data
);

    typedef enum logic {
        DS_HEAD,
        DS_TAIL
    } ds_state_e;

    ds_state_e          st_q, st_d;
    logic [BEAT_W-1:0]  head_q;
    logic [TAG_W-1:0]   tag_in;
    logic               want_two;
    logic               push, pop;
    logic [TAG_W-1:0]   push_kind;
    logic [DATA_W-1:0]  push_data;
    logic [PTR_W-1:0]   wr_q, rd_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [TAG_W-1:0]   kind_arr [DEPTH];
    logic [DATA_W-1:0]  data_arr [DEPTH];

    assign tag_in   = beat[BEAT_W-1 -: TAG_W];
    assign want_two = TWO_MASK[tag_in];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DS_HEAD;
            head_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == DS_HEAD && beat_vld) head_q <= beat;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DS_HEAD: if (beat_vld && want_two) st_d = DS_TAIL;
            DS_TAIL: if (beat_vld)             st_d = DS_HEAD;
            default: st_d = DS_HEAD;
        endcase
    end

    // outputs of the assembler
    always_comb begin
        push      = 1'b0;
        push_kind = tag_in;
        push_data = {{BEAT_W{1'b0}}, beat[BEAT_W-TAG_W-1:0]};
        unique case (st_q)
            DS_HEAD: push = beat_vld && !want_two;
            DS_TAIL: begin
                push      = beat_vld;
                push_kind = head_q[BEAT_W-1 -: TAG_W];
                push_data = {head_q[BEAT_W-TAG_W-1:0], beat};
            end
            default: push = 1'b0;
        endcase
    end

    // packet buffer
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [TAG_W-1:0]  kind_s;
        logic [DATA_W-1:0] data_s;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                kind_s <= '0;
                data_s <= '0;
            end else if (push && wr_q == PTR_W'(g)) begin
                kind_s <= push_kind;
                data_s <= push_data;
            end
        end
        assign kind_arr[g] = kind_s;
        assign data_arr[g] = data_s;
    end

    assign out_valid = (cnt_q != '0);
    assign ch_ready  = (cnt_q != CNT_W'(DEPTH));
    assign pop       = phase && out_valid && out_ready;
    assign out_kind  = kind_arr[rd_q];
    assign out_data  = data_arr[rd_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) // R9
        push |-> (cnt_q != CNT_W'(DEPTH)));

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R10
        (out_valid && !(phase && out_ready)) |=>
            (out_valid && $stable(out_data) && $stable(out_kind)));

endmodule

// File: rtl/fwd_arb.sv
module fwd_arb
    import link_pkg::*;
#(
    parameter  int FWD_W = 64,
    localparam int PKT_W = 2 * FWD_W,
    localparam int INS_W = PKT_W - TAG_W,
    localparam int CTL_W = FWD_W - TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             can_load,
    input  logic             ins_valid,
    input  logic [INS_W-1:0] ins_data,
    input  logic             ctl_valid,
    input  logic [CTL_W-1:0] ctl_data,
    output logic             ins_ready,
    output logic             ctl_ready,
    output logic             ld_en,
    output logic [PKT_W-1:0] ld_pkt,
    output logic             ld_two
);

    always_comb begin
        ctl_ready = can_load;
        ins_ready = can_load && !ctl_valid;
        ld_en     = can_load && (ctl_valid || ins_valid);
        ld_two    = !ctl_valid;
        if (ctl_valid) ld_pkt = {KIND_CTRL, ctl_data, {FWD_W{1'b0}}};
        else           ld_pkt = {KIND_INSTR, ins_data};
    end

    AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (!rst_n) // R5
        (ctl_valid && ins_valid && ctl_ready) |-> !ins_ready);

endmodule

// File: rtl/fe_link_top.sv
module fe_link_top
    import link_pkg::*;
#(
    parameter  int FWD_W     = 64,
    parameter  int REV_W     = 16,
    parameter  int BUF_DEPTH = 2,
    localparam int INS_W     = 2 * FWD_W - TAG_W,
    localparam int CTL_W     = FWD_W - TAG_W,
    localparam int ACK_W     = 2 * REV_W - TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [INS_W-1:0] ins_data,
    input  logic             ctl_valid,
    output logic             ctl_ready,
    input  logic [CTL_W-1:0] ctl_data,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [1:0]       pkt_kind,
    output logic [INS_W-1:0] pkt_data,
    input  logic             ack_in_valid,
    output logic             ack_in_ready,
    input  logic [ACK_W-1:0] ack_in_data,
    output logic             ack_out_valid,
    input  logic             ack_out_ready,
    output logic [ACK_W-1:0] ack_out_data,
    output logic             fwd_beat_vld,
    output logic [FWD_W-1:0] fwd_beat,
    output logic             rev_beat_vld,
    output logic [REV_W-1:0] rev_beat
);

    logic               f_can, f_ld, f_two, f_chr;
    logic [2*FWD_W-1:0] f_pkt;
    logic               r_can, r_ld, r_chr;
    logic [2*REV_W-1:0] r_pkt;
    logic [TAG_W-1:0]   r_kind;

    fwd_arb #(.FWD_W(FWD_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .can_load  (f_can),
        .ins_valid (ins_valid),
        .ins_data  (ins_data),
        .ctl_valid (ctl_valid),
        .ctl_data  (ctl_data),
        .ins_ready (ins_ready),
        .ctl_ready (ctl_ready),
        .ld_en     (f_ld),
        .ld_pkt    (f_pkt),
        .ld_two    (f_two)
    );

    link_ser #(.BEAT_W(FWD_W)) u_fwd_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .ld_en    (f_ld),
        .ld_pkt   (f_pkt),
        .ld_two   (f_two),
        .can_load (f_can),
        .ch_ready (f_chr),
        .beat_vld (fwd_beat_vld),
        .beat     (fwd_beat)
    );

    link_deser #(.BEAT_W(FWD_W), .TWO_MASK(4'b0001), .DEPTH(BUF_DEPTH)) u_fwd_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .beat_vld  (fwd_beat_vld),
        .beat      (fwd_beat),
        .ch_ready  (f_chr),
        .out_valid (pkt_valid),
        .out_ready (pkt_ready),
        .out_kind  (pkt_kind),
        .out_data  (pkt_data)
    );

    assign r_pkt        = {KIND_MACK, ack_in_data};
    assign r_ld         = r_can && ack_in_valid;
    assign ack_in_ready = r_can;

    link_ser #(.BEAT_W(REV_W)) u_rev_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .ld_en    (r_ld),
        .ld_pkt   (r_pkt),
        .ld_two   (1'b1),
        .can_load (r_can),
        .ch_ready (r_chr),
        .beat_vld (rev_beat_vld),
        .beat     (rev_beat)
    );

    link_deser #(.BEAT_W(REV_W), .TWO_MASK(4'b0010), .DEPTH(BUF_DEPTH)) u_rev_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .beat_vld  (rev_beat_vld),
        .beat      (rev_beat),
        .ch_ready  (r_chr),
        .out_valid (ack_out_valid),
        .out_ready (ack_out_ready),
        .out_kind  (r_kind),
        .out_data  (ack_out_data)
    );

    AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n) // R2
        phase |=> !phase);

    AST_PHASE_RET: assert property (@(posedge clk) disable iff (!rst_n) // R2
        !phase |=> phase);

    AST_ACCEPT_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n) // R2
        ((ins_valid && ins_ready) || (ctl_valid && ctl_ready) || (ack_in_valid && ack_in_ready)) |-> phase);

    AST_ACK_KIND: assert property (@(posedge clk) disable iff (!rst_n) // R8
        ack_out_valid |-> (r_kind == KIND_MACK));

endmodule

// File: tb/sim_fe_link_top.sv
module sim_fe_link_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         phase;
    logic         ins_valid, ins_ready;
    logic [125:0] ins_data;
    logic         ctl_valid, ctl_ready;
    logic [61:0]  ctl_data;
    logic         pkt_valid, pkt_ready;
    logic [1:0]   pkt_kind;
    logic [125:0] pkt_data;
    logic         ack_in_valid, ack_in_ready;
    logic [29:0]  ack_in_data;
    logic         ack_out_valid, ack_out_ready;
    logic [29:0]  ack_out_data;
    logic         fwd_beat_vld;
    logic [63:0]  fwd_beat;
    logic         rev_beat_vld;
    logic [15:0]  rev_beat;

    always #5 clk = ~clk;

    fe_link_top u0 (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_kind(pkt_kind), .pkt_data(pkt_data),
        .ack_in_valid(ack_in_valid), .ack_in_ready(ack_in_ready), .ack_in_data(ack_in_data),
        .ack_out_valid(ack_out_valid), .ack_out_ready(ack_out_ready), .ack_out_data(ack_out_data),
        .fwd_beat_vld(fwd_beat_vld), .fwd_beat(fwd_beat),
        .rev_beat_vld(rev_beat_vld), .rev_beat(rev_beat)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit ph    = 0;
    bit rdy_pkt = 1, rdy_ack = 1;
    int acc_ins = 0;

    // stimulus queues
    logic [125:0] insq[$];
    logic [61:0]  ctlq[$];
    logic [29:0]  ackq[$];
    // forward model: pending beats, tail flags, finished packets
    logic [63:0]  ftb[$];
    bit           ftt[$];
    logic [1:0]   fsk[$];
    logic [125:0] fsd[$];
    logic [63:0]  fhead;
    // reverse model
    logic [15:0]  rtb[$];
    bit           rtt[$];
    logic [29:0]  rsd[$];
    logic [15:0]  rhead;
    // previous-cycle output state for hold checks
    bit           p_pv, p_ppop, p_av, p_apop;
    logic [1:0]   p_k;
    logic [125:0] p_d;
    logic [29:0]  p_a;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic push_ins();
        logic [127:0] t = {$urandom(), $urandom(), $urandom(), $urandom()};
        insq.push_back(t[125:0]);
    endtask

    task automatic push_ctl();
        logic [63:0] t = {$urandom(), $urandom()};
        ctlq.push_back(t[61:0]);
    endtask

    task automatic push_ack();
        logic [31:0] t = $urandom();
        ackq.push_back(t[29:0]);
    endtask

    task automatic model_cycle();
        bit f_send, f_can, r_send, r_can;
        logic [63:0] b;
        logic [15:0] rb;
        bit t;
        // hold checks from previous cycle (R10)
        if (p_pv && !p_ppop)
            chk(pkt_valid && pkt_kind == p_k && pkt_data == p_d, "R10 hold", {pkt_kind, pkt_data}, {p_k, p_d});
        if (p_av && !p_apop)
            chk(ack_out_valid && ack_out_data == p_a, "R10 ack hold", ack_out_data, p_a);

        f_send = (ftb.size() > 0) && (ftt[0] || fsk.size() < 2);
        f_can  = ph && (ftb.size() == 0 || (ftb.size() == 1 && f_send));
        r_send = (rtb.size() > 0) && (rtt[0] || rsd.size() < 2);
        r_can  = ph && (rtb.size() == 0 || (rtb.size() == 1 && r_send));

        if (!ph) chk(!ins_ready && !ctl_ready && !ack_in_ready, "R2 ready off-phase",
                     {ins_ready, ctl_ready, ack_in_ready}, 0);
        chk(ctl_ready == f_can, "R2 ctl_ready", ctl_ready, f_can);
        chk(ins_ready == (f_can && !ctl_valid), "R5 ins_ready", ins_ready, f_can && !ctl_valid);
        if (ph && ctl_valid && ins_valid && ctl_ready)
            chk(!ins_ready, "R5 ctrl priority", ins_ready, 0);
        chk(fwd_beat_vld == f_send, "R9 fwd beat valid", fwd_beat_vld, f_send);
        if (f_send && fwd_beat_vld)
            chk(fwd_beat == ftb[0], (ftt[0] || ftb[0][63:62] == 2'b00) ? "R3 instr beat" : "R4 ctrl beat",
                fwd_beat, ftb[0]);
        chk(pkt_valid == (fsk.size() > 0), "R7 pkt_valid", pkt_valid, fsk.size() > 0);
        if (pkt_valid && fsk.size() > 0)
            chk(pkt_kind == fsk[0] && pkt_data == fsd[0], "R7/R10 pkt content",
                {pkt_kind, pkt_data}, {fsk[0], fsd[0]});

        chk(ack_in_ready == r_can, "R8 ack_in_ready", ack_in_ready, r_can);
        chk(rev_beat_vld == r_send, "R8 rev beat valid", rev_beat_vld, r_send);
        if (r_send && rev_beat_vld) chk(rev_beat == rtb[0], "R8 rev beat", rev_beat, rtb[0]);
        chk(ack_out_valid == (rsd.size() > 0), "R8 ack_out_valid", ack_out_valid, rsd.size() > 0);
        if (ack_out_valid && rsd.size() > 0)
            chk(ack_out_data == rsd[0], "R8 ack_out_data", ack_out_data, rsd[0]);

        if (ins_valid && ins_ready) acc_ins++;
        p_pv = pkt_valid; p_k = pkt_kind; p_d = pkt_data; p_ppop = ph && pkt_valid && pkt_ready;
        p_av = ack_out_valid; p_a = ack_out_data; p_apop = ph && ack_out_valid && ack_out_ready;

        // advance forward model
        if (ph && fsk.size() > 0 && pkt_ready) begin fsk.delete(0); fsd.delete(0); end
        if (f_send) begin
            b = ftb.pop_front(); t = ftt.pop_front();
            if (t) begin fsk.push_back(2'b00); fsd.push_back({fhead[61:0], b}); end
            else if (b[63:62] == 2'b00) fhead = b;
            else begin fsk.push_back(b[63:62]); fsd.push_back({64'b0, b[61:0]}); end
        end
        if (f_can && ctl_valid) begin
            ftb.push_back({2'b10, ctlq[0]}); ftt.push_back(1'b0); ctlq.delete(0);
        end else if (f_can && ins_valid) begin
            ftb.push_back({2'b00, insq[0][125:64]}); ftt.push_back(1'b0);
            ftb.push_back(insq[0][63:0]);            ftt.push_back(1'b1);
            insq.delete(0);
        end
        // advance reverse model
        if (ph && rsd.size() > 0 && ack_out_ready) rsd.delete(0);
        if (r_send) begin
            rb = rtb.pop_front(); t = rtt.pop_front();
            if (t) rsd.push_back({rhead[13:0], rb});
            else   rhead = rb;
        end
        if (r_can && ack_in_valid) begin
            rtb.push_back({2'b01, ackq[0][29:16]}); rtt.push_back(1'b0);
            rtb.push_back(ackq[0][15:0]);           rtt.push_back(1'b1);
            ackq.delete(0);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ph    = ~ph;
        phase = ph;
        ins_valid    = insq.size() > 0;
        ins_data     = ins_valid ? insq[0] : '0;
        ctl_valid    = ctlq.size() > 0;
        ctl_data     = ctl_valid ? ctlq[0] : '0;
        ack_in_valid = ackq.size() > 0;
        ack_in_data  = ack_in_valid ? ackq[0] : '0;
        pkt_ready     = rdy_pkt;
        ack_out_ready = rdy_ack;
        #1;
        if (rst_n) model_cycle();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; phase = 1'b0;
        ins_valid = 0; ins_data = '0; ctl_valid = 0; ctl_data = '0;
        ack_in_valid = 0; ack_in_data = '0; pkt_ready = 1; ack_out_ready = 1;
        p_pv = 0; p_ppop = 0; p_av = 0; p_apop = 0; p_k = '0; p_d = '0; p_a = '0;
        fhead = '0; rhead = '0;
        run(6);
        chk(!pkt_valid && !ack_out_valid && !fwd_beat_vld && !rev_beat_vld, "R1 in reset",
            {pkt_valid, ack_out_valid, fwd_beat_vld, rev_beat_vld}, 0);
        @(negedge clk); rst_n = 1'b1;
        step();
        chk(!pkt_valid && !ack_out_valid && !fwd_beat_vld && !rev_beat_vld, "R1 after reset",
            {pkt_valid, ack_out_valid, fwd_beat_vld, rev_beat_vld}, 0);
        run(3);

        // single instruction, then single control message (R3, R4, R7)
        push_ins(); run(10);
        push_ctl(); run(10);
        // simultaneous offer (R5)
        push_ins(); push_ctl(); run(14);

        // back-to-back throughput (R6)
        for (int i = 0; i < 12; i++) push_ins();
        acc_ins = 0;
        run(20);
        chk(acc_ins == 10, "R6 one instr per core cycle", acc_ins, 10);
        run(20);

        // acknowledgements, free and stalled (R8)
        for (int i = 0; i < 4; i++) push_ack();
        run(20);
        rdy_ack = 0;
        for (int i = 0; i < 4; i++) push_ack();
        run(20);
        chk(!rev_beat_vld && ackq.size() == 1, "R9 reverse blocked", {rev_beat_vld, 8'(ackq.size())}, 1);
        rdy_ack = 1; run(20);

        // forward backpressure (R9)
        rdy_pkt = 0;
        for (int i = 0; i < 5; i++) push_ins();
        run(30);
        chk(!fwd_beat_vld, "R9 forward blocked", fwd_beat_vld, 0);
        chk(insq.size() == 2, "R9 one extra held", insq.size(), 2);
        chk(pkt_valid, "R9 buffer holds data", pkt_valid, 1);
        rdy_pkt = 1; run(30);

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) == 0 && insq.size() < 4) push_ins();
            if ($urandom_range(0, 4) == 0 && ctlq.size() < 3) push_ctl();
            if ($urandom_range(0, 2) == 0 && ackq.size() < 4) push_ack();
            rdy_pkt = ($urandom_range(0, 3) != 0);
            rdy_ack = ($urandom_range(0, 3) != 0);
            step();
        end
        rdy_pkt = 1; rdy_ack = 1;
        run(60);
        chk(insq.size() == 0 && ctlq.size() == 0 && ackq.size() == 0 && fsk.size() == 0 && rsd.size() == 0,
            "R10 all delivered", insq.size() + ctlq.size() + ackq.size() + fsk.size() + rsd.size(), 0);
        finish_run();
    end

endmodule